// File: doc/BRIEF.md
# DDR Four-Word Burst SRAM

This block is a synthesizable behavioural model of a burst SRAM with a double-data-rate port. It runs from a single internal clock at twice the input-clock rate. Alternate edges of that clock stand for the rising edges of the true and complemented input clock, starting with a true-clock rise after reset. A command is sampled only on a true-clock edge. Every access then moves four data words over the four edges that follow one idle edge. The two low address bits seed a counter that wraps inside the aligned group of four words.

Writes are posted. The four beats of a write collect in a holding register, along with a byte-enable mask for each beat. That register is copied into the array only when the next write delivers its first beat, so the array write never clashes with a read burst. A read that addresses the held row takes any enabled held bytes in place of the array bytes, so reads always see the latest write. Read data comes with an output-enable flag that stands for the pad tri-state. The block also drives a free-running echo clock that is high after each true-clock edge.

Top module: `ddr_burst_sram`

## Requirements
- R1: After reset `qOe`, `qOut` and `echoClk` are 0, and `qOut` is 0 whenever `qOe` is 0.
- R2: On a true-clock edge, `loadN`=0 with `rdWrN`=1 starts a read and `loadN`=0 with `rdWrN`=0 starts a write. `loadN`=1 is a no-op whatever the address, data and byte-select values are.
- R3: A load on the true-clock edge right after an accepted load is ignored, so commands are accepted at most on every other true-clock edge (every fourth fast edge).
- R4: With start offset s (address bits 1:0), the four beats use offsets s, s+1, s+2, s+3 modulo 4, and the upper address bits stay fixed.
- R5: For a command accepted at fast edge T, write data and byte selects are sampled at edges T+2, T+3, T+4 and T+5, one beat each.
- R6: For a read accepted at fast edge T, the four words appear on `qOut` with `qOe`=1 after edges T+2 through T+5, one word per edge. Back-to-back reads give an unbroken stream.
- R7: `byteWrN` is active low and sampled with every beat. Bit 0 gates data bits 8:0 and bit 1 gates bits 17:9. A byte whose select is 1 keeps its stored value, and the mask may differ between beats.
- R8: A write's data stays in the holding register and is committed to the array at the first data beat of the next write. It is not lost when reads come in between.
- R9: A read of words held in the holding register returns the held bytes merged with the array bytes.
- R10: `qOe` falls only on a true-clock edge. This is the first one after the last read beat with no new read beat, and `qOe` stays 0 during writes and idle cycles.
- R11: `echoClk` toggles on every fast edge, is 1 after true-clock edges, and never stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; alternate edges are true and complemented input-clock rises |
| rstN | input | 1 | Active-low synchronous reset |
| loadN | input | 1 | Active-low command load strobe |
| rdWrN | input | 1 | Access direction: 1 read, 0 write |
| addr | input | AW | Word address; bits 1:0 seed the burst counter |
| byteWrN | input | BW | Active-low byte write selects, one per data byte |
| dIn | input | DW | Write data beat |
| qOut | output | DW | Read data beat |
| qOe | output | 1 | Output enable (high = bus driven) |
| echoClk | output | 1 | Free-running echo clock |

## Verification
The bench builds the block with its defaults: 18-bit data split into two 9-bit bytes and a 6-bit address, giving sixteen four-word rows. With only sixteen rows the bench can write a few rows and read them back at different start offsets, which covers every wrap position of the burst counter. The small depth also puts a posted write, a read of the same held row and the later commit inside a few dozen cycles. The two-byte width keeps every mask pattern in reach: both bytes, either byte alone, or none in a beat.

// File: rtl/ddr_burst_sram_pkg.sv
package ddr_burst_sram_pkg;

  // Per-edge strobes from the control to the datapath.
  typedef struct packed {
    logic       posEdge;   // this fast edge is a true-clock rise
    logic       beatEn;    // a data beat happens on this edge
    logic       beatRead;  // beat belongs to a read burst
    logic [1:0] beatOff;   // word offset inside the aligned group
    logic       commit;    // first beat of a write: flush holding register
  } beatStrb_t;

endpackage

// File: rtl/ddr_burst_ctrl.sv
module ddr_burst_ctrl
  import ddr_burst_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadN,
  input  logic          rdWrN,
  input  logic [AW-1:0] addr,
  output beatStrb_t     strb,
  output logic [AW-3:0] beatRow,
  output logic          echoClk
);

  localparam int RW = AW - 2;

  logic          negNext;   // 1: the coming edge is a complemented-clock rise
  logic          cmdV;
  logic          cmdRd;
  logic [AW-1:0] cmdAddr;
  logic          actV;
  logic          actRd;
  logic [AW-1:0] actAddr;
  logic [1:0]    actIdx;

  logic accept;
  logic launch;

  assign accept = !negNext && !loadN && !cmdV;
  assign launch = !negNext && cmdV;

  always_comb begin
    strb         = '0;
    beatRow      = '0;
    strb.posEdge = !negNext;
    if (launch) begin
      strb.beatEn   = 1'b1;
      strb.beatRead = cmdRd;
      strb.beatOff  = cmdAddr[1:0];
      strb.commit   = !cmdRd;
      beatRow       = cmdAddr[AW-1:2];
    end else if (actV) begin
      strb.beatEn   = 1'b1;
      strb.beatRead = actRd;
      strb.beatOff  = actAddr[1:0] + actIdx;
      beatRow       = actAddr[AW-1:2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      negNext <= 1'b0;
      cmdV    <= 1'b0;
      cmdRd   <= 1'b0;
      cmdAddr <= '0;
      actV    <= 1'b0;
      actRd   <= 1'b0;
      actAddr <= '0;
      actIdx  <= '0;
    end else begin
      negNext <= !negNext;
      if (launch) begin
        cmdV    <= 1'b0;
        actV    <= 1'b1;
        actRd   <= cmdRd;
        actAddr <= cmdAddr;
        actIdx  <= 2'd1;
      end else if (actV) begin
        actIdx <= actIdx + 2'd1;
        if (actIdx == 2'd3) actV <= 1'b0;
      end
      if (accept) begin
        cmdV    <= 1'b1;
        cmdRd   <= rdWrN;
        cmdAddr <= addr;
      end
    end
  end

  assign echoClk = negNext;

  logic unusedRw;
  assign unusedRw = ^RW;

endmodule

// File: rtl/ddr_burst_dpath.sv
module ddr_burst_dpath
  import ddr_burst_sram_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  beatStrb_t     strb,
  input  logic [AW-3:0] beatRow,
  input  logic [BW-1:0] byteWrN,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] qOut,
  output logic          qOe
);

  localparam int ROWS  = 2 ** (AW - 2);
  localparam int BYTEW = DW / BW;

  logic [DW-1:0] memArr   [ROWS][4];
  logic [DW-1:0] heldData [4];
  logic [BW-1:0] heldMask [4];
  logic [AW-3:0] heldRow;
  logic [DW-1:0] rdWord;
  logic          wrBeat;

  assign wrBeat = strb.beatEn && !strb.beatRead;

  // Coherent read word: held bytes override the array.
  always_comb begin
    rdWord = memArr[beatRow][strb.beatOff];
    for (int b = 0; b < BW; b++) begin
      if (heldRow == beatRow && heldMask[strb.beatOff][b])
        rdWord[b*BYTEW +: BYTEW] = heldData[strb.beatOff][b*BYTEW +: BYTEW];
    end
  end

  // Array: committed from the holding register at the next write.
  always_ff @(posedge clk) begin
    if (rstN && wrBeat && strb.commit) begin
      for (int o = 0; o < 4; o++) begin
        for (int b = 0; b < BW; b++) begin
          if (heldMask[o][b])
            memArr[heldRow][o][b*BYTEW +: BYTEW] <= heldData[o][b*BYTEW +: BYTEW];
        end
      end
    end
  end

  // Holding register data (no reset needed: qualified by the mask).
  always_ff @(posedge clk) begin
    if (wrBeat) begin
      for (int b = 0; b < BW; b++) begin
        if (!byteWrN[b])
          heldData[strb.beatOff][b*BYTEW +: BYTEW] <= dIn[b*BYTEW +: BYTEW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int o = 0; o < 4; o++) heldMask[o] <= '0;
      heldRow <= '0;
    end else if (wrBeat) begin
      if (strb.commit) begin
        for (int o = 0; o < 4; o++) heldMask[o] <= '0;
        heldRow <= beatRow;
      end
      heldMask[strb.beatOff] <= ~byteWrN;
    end
  end

  // Output register and enable.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qOut <= '0;
      qOe  <= 1'b0;
    end else if (strb.beatEn && strb.beatRead) begin
      qOut <= rdWord;
      qOe  <= 1'b1;
    end else if (strb.posEdge) begin
      qOut <= '0;
      qOe  <= 1'b0;
    end
  end

endmodule

// File: rtl/ddr_burst_sram.sv
module ddr_burst_sram
  import ddr_burst_sram_pkg::*;
#(
  parameter int DW = 18,
  parameter int AW = 6,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadN,
  input  logic          rdWrN,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] byteWrN,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] qOut,
  output logic          qOe,
  output logic          echoClk
);

  beatStrb_t     strb;
  logic [AW-3:0] beatRow;

  ddr_burst_ctrl #(.AW(AW)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadN   (loadN),
    .rdWrN   (rdWrN),
    .addr    (addr),
    .strb    (strb),
    .beatRow (beatRow),
    .echoClk (echoClk)
  );

  ddr_burst_dpath #(.DW(DW), .AW(AW), .BW(BW)) i_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .beatRow (beatRow),
    .byteWrN (byteWrN),
    .dIn     (dIn),
    .qOut    (qOut),
    .qOe     (qOe)
  );

endmodule

// File: rtl/ddr_burst_sram_chk.sv
module ddr_burst_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rstN,
  input logic [DW-1:0] qOut,
  input logic          qOe,
  input logic          echoClk
);

  // R11: echo clock toggles on every fast edge
  p_echo_toggle_r11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (echoClk != $past(echoClk)));

  // R1: bus reads as zero while not driven
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !qOe |-> (qOut == '0));

  // R6: a read burst starts on a true-clock edge and lasts four beats
  p_rise_pos_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qOe) |-> echoClk);

  p_burst_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qOe) |=> qOe ##1 qOe ##1 qOe);

  // R10: the bus is released only on a true-clock edge
  p_fall_pos_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qOe) |-> echoClk);

endmodule

bind ddr_burst_sram ddr_burst_sram_chk #(.DW(DW)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .qOut    (qOut),
  .qOe     (qOe),
  .echoClk (echoClk)
);

// File: tb/test_ddr_burst_sram.sv
`timescale 1ns/1ps
module test_ddr_burst_sram;

  localparam int DW = 18;
  localparam int AW = 6;
  localparam int BW = 2;
  localparam int BYTEW = DW / BW;
  localparam int NT = 56;
  localparam int NWORDS = 2 ** AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadN = 1'b1;
  logic          rdWrN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] byteWrN = '1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] qOut;
  logic          qOe;
  logic          echoClk;

  always #10 clk = ~clk;

  ddr_burst_sram #(.DW(DW), .AW(AW), .BW(BW)) i_ddr_burst_sram (
    .clk(clk), .rstN(rstN), .loadN(loadN), .rdWrN(rdWrN), .addr(addr),
    .byteWrN(byteWrN), .dIn(dIn), .qOut(qOut), .qOe(qOe), .echoClk(echoClk)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Per-tick input schedule
  logic          sLoadN [NT];
  logic          sRw    [NT];
  logic [AW-1:0] sAddr  [NT];
  logic [DW-1:0] sD     [NT];
  logic [BW-1:0] sBw    [NT];
  logic [DW-1:0] shadow [NWORDS];

  // Scoreboard
  int            expTick [$];
  logic [DW-1:0] expVal  [$];
  string         expReq  [$];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int wordOf(input int a, input int i);
    return (a & ~3) | ((a + i) & 3);
  endfunction

  task automatic planWrite(input int t, input int a, input logic [4*DW-1:0] ws,
                           input logic [4*BW-1:0] ms);
    sLoadN[t] = 1'b0; sRw[t] = 1'b0; sAddr[t] = AW'(a);
    for (int i = 0; i < 4; i++) begin
      sD[t+2+i]  = ws[i*DW +: DW];
      sBw[t+2+i] = ms[i*BW +: BW];
      for (int b = 0; b < BW; b++)
        if (!ms[i*BW + b])
          shadow[wordOf(a, i)][b*BYTEW +: BYTEW] = ws[i*DW + b*BYTEW +: BYTEW];
    end
  endtask

  task automatic planRead(input int t, input int a, input string req);
    sLoadN[t] = 1'b0; sRw[t] = 1'b1; sAddr[t] = AW'(a);
    for (int i = 0; i < 4; i++) begin
      expTick.push_back(t + 2 + i);
      expVal.push_back(shadow[wordOf(a, i)]);
      expReq.push_back(req);
    end
  endtask

  // Watchdog
  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NT; k++) begin
      sLoadN[k] = 1'b1; sRw[k] = 1'b1; sAddr[k] = AW'(k * 5);
      sD[k] = DW'(18'h2AAAA ^ k); sBw[k] = '0;
    end
    for (int w = 0; w < NWORDS; w++) shadow[w] = '0;

    // R5/R2: full write, row 1 offset 0
    planWrite(0, 6'h04, {18'h0A004, 18'h0A003, 18'h0A002, 18'h0A001}, 8'h00);
    // write row 2 starting at offset 1 (stays posted until tick 18)
    planWrite(4, 6'h09, {18'h1B004, 18'h1B003, 18'h1B002, 18'h1B001}, 8'h00);
    // R4: read starting at offset 1
    planRead(8, 6'h05, "R4");
    // R3: load on the next true-clock edge is ignored
    sLoadN[10] = 1'b0; sRw[10] = 1'b0; sAddr[10] = 6'h05;
    // R9: read of the posted row, start offset 2
    planRead(12, 6'h0A, "R9");
    // R7: per-beat masks, start offset 3 (words 7,4,5,6)
    planWrite(16, 6'h07, {18'h3C6C6, 18'h3C5C5, 18'h3C4C4, 18'h3C7C7},
              {2'b00, 2'b11, 2'b10, 2'b01});
    planRead(20, 6'h04, "R7");
    // R8: row 2 now committed to the array
    planRead(24, 6'h09, "R8");
    planWrite(28, 6'h30, {18'h24444, 18'h23333, 18'h22222, 18'h21111}, 8'h00);
    planRead(36, 6'h32, "R9");
    // R4: wrap from offset 3
    planRead(44, 6'h0B, "R4");

    // Reset
    repeat (3) @(negedge clk);
    check(qOe == 1'b0, "R1", DW'(qOe), '0, "qOe in reset");
    check(qOut == '0, "R1", qOut, '0, "qOut in reset");
    check(echoClk == 1'b0, "R1", DW'(echoClk), '0, "echoClk in reset");
    rstN = 1'b1;

    for (int k = 0; k < NT; k++) begin
      loadN = sLoadN[k]; rdWrN = sRw[k]; addr = sAddr[k];
      dIn = sD[k]; byteWrN = sBw[k];
      @(posedge clk);
      @(negedge clk);
      check(echoClk == ((k % 2) == 0), "R11", DW'(echoClk), DW'((k % 2) == 0), "echo phase");
      if (expTick.size() > 0 && expTick[0] == k) begin
        check(qOe == 1'b1, "R6", DW'(qOe), 1, $sformatf("qOe at tick %0d", k));
        check(qOut == expVal[0], expReq[0], qOut, expVal[0], $sformatf("beat at tick %0d", k));
        void'(expTick.pop_front());
        void'(expVal.pop_front());
        void'(expReq.pop_front());
      end else begin
        check(qOe == 1'b0, "R10", DW'(qOe), 0, $sformatf("idle qOe tick %0d", k));
        check(qOut == '0, "R1", qOut, '0, $sformatf("idle qOut tick %0d", k));
      end
    end
    check(expTick.size() == 0, "R6", DW'(expTick.size()), 0, "beats left over");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule